// File: doc/BRIEF.md
# JTAG Two-Pass Debug Register Access Client

This block lets a debug host reach a bank of internal debug registers through the data register path of a JTAG TAP. Every access takes two consecutive data-register scans. The selection scan carries a register index and a direction flag. The data scan that follows then moves 32 bits of register content out to the host, or in from the host. The TAP controller is outside the block. It supplies decoded one-cycle state strobes for capture-DR, shift-DR, update-DR and test-logic-reset, and the block runs on TCK.

On the target side the block drives a plain register-file port. The port has an index bus, a read strobe with combinational read data, and a write strobe with write data. This port has no back-pressure. The register file must return read data in the same cycle as the read strobe, and it must accept a write in the cycle the write strobe is high. The TAP has no way to stall, so no valid/ready handshake is offered. The serial chain is the only data stream, and its pace is set entirely by the host's shift-DR cycles.

Top module: `jtag_regacc_client`

## Requirements
- R1: A selection scan shifts its chain least significant bit first. Bits [6:0] are the register index, and bit 7 is the direction flag (0 = read, 1 = write). The index and the flag take effect at the update-DR of that scan.
- R2: At capture-DR of a selection scan, the chain loads the current selection {direction, index}, so the host shifts the present selection out on `tdo`, index bit 0 first.
- R3: Scans alternate strictly. The update-DR of a selection scan makes the next scan a data scan, and the update-DR of a data scan makes the next scan a selection scan.
- R4: In a read data scan, the selected register's value is loaded at capture-DR, and `rf_rd_en` is high for that one cycle. The value then appears on `tdo` bit 0 first, one bit per shift-DR cycle.
- R5: In a write data scan, `rf_wr_en` is high for exactly the update-DR cycle. In that cycle `rf_wr_data` holds the last 32 bits shifted in, with the first bit shifted landing in bit 0.
- R6: An index of `NUM_REGS` or more maps to no register. A read of such an index returns zero, and neither `rf_rd_en` nor `rf_wr_en` is raised for it.
- R7: `tap_tlr` high at a TCK edge, or `rst_n` low, returns the block to expecting a selection scan with index 0 and direction read.
- R8: `rf_addr` always shows the committed index. `rf_rd_en` and `rf_wr_en` are never high together, and neither is high outside a data scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tap_tlr | input | 1 | TAP is in test-logic-reset |
| tap_capture_dr | input | 1 | TAP is in capture-DR |
| tap_shift_dr | input | 1 | TAP is in shift-DR |
| tap_update_dr | input | 1 | TAP is in update-DR |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial data to the host (bit 0 of the active chain) |
| rf_addr | output | 7 | Committed register index |
| rf_rd_en | output | 1 | Read strobe, one cycle at capture-DR of a mapped read |
| rf_rd_data | input | 32 | Register-file read data, valid in the read-strobe cycle |
| rf_wr_en | output | 1 | Write strobe, one cycle at update-DR of a mapped write |
| rf_wr_data | output | 32 | Write data, valid in the write-strobe cycle |

## Verification
The assertions assume that the TAP strobes arrive as a decoded state, so at most one of capture-DR, shift-DR and update-DR is high in any cycle. They also assume that the register file answers a read in the same cycle as the read strobe. The bench produces every scan with a single task that raises capture, then shift, then update on successive falling edges. Test-logic-reset is pulsed only between scans. A register-file model in the bench returns read data combinationally and returns a poison value for unmapped indices, so a missing zero mask is exposed. The random accesses draw indices across the full 7-bit range, which covers mapped and unmapped registers in both directions.

// File: rtl/jtp_pkg.sv
package jtp_pkg;
  typedef enum logic {
    PASS_SEL  = 1'b0,
    PASS_DATA = 1'b1
  } pass_e;

  localparam logic DIR_READ  = 1'b0;
  localparam logic DIR_WRITE = 1'b1;
endpackage

// File: rtl/jtp_pass_ctl.sv
module jtp_pass_ctl
  import jtp_pkg::*;
(
  input  logic  tck,
  input  logic  rst_n,
  input  logic  tlr,
  input  logic  update_dr,
  output pass_e pass
);
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)          pass <= PASS_SEL;
    else if (tlr)        pass <= PASS_SEL;
    else if (update_dr)  pass <= (pass == PASS_SEL) ? PASS_DATA : PASS_SEL;
  end

  // R3: each completed scan flips the expected scan kind
  p_alternate_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (update_dr && !tlr) |=> (pass != $past(pass)));

  p_hold_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (!update_dr && !tlr) |=> $stable(pass));
endmodule

// File: rtl/jtp_sel_chain.sv
module jtp_sel_chain #(
  parameter int IDX_W = 7
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tlr,
  input  logic             en,
  input  logic             capture_dr,
  input  logic             shift_dr,
  input  logic             update_dr,
  input  logic             tdi,
  output logic [IDX_W-1:0] idx,
  output logic             dir,
  output logic             so
);
  localparam int SEL_W = IDX_W + 1;

  logic [SEL_W-1:0] chain;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      idx   <= '0;
      dir   <= 1'b0;
    end else if (tlr) begin
      chain <= '0;
      idx   <= '0;
      dir   <= 1'b0;
    end else if (en) begin
      if (capture_dr)
        chain <= {dir, idx};
      else if (shift_dr)
        chain <= {tdi, chain[SEL_W-1:1]};
      else if (update_dr) begin
        idx <= chain[IDX_W-1:0];
        dir <= chain[SEL_W-1];
      end
    end
  end

  assign so = chain[0];

  // R1: the selection only changes at update-DR of a selection scan
  p_sel_hold_r1: assert property (@(posedge tck) disable iff (!rst_n)
    !(en && update_dr) && !tlr |=> ($stable(idx) && $stable(dir)));
endmodule

// File: rtl/jtp_data_chain.sv
module jtp_data_chain #(
  parameter int IDX_W    = 7,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 100
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tlr,
  input  logic              en,
  input  logic              dir,
  input  logic [IDX_W-1:0]  idx,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              so
);
  import jtp_pkg::*;

  localparam logic [31:0] NREG = 32'(NUM_REGS);

  logic [DATA_W-1:0] chain;
  logic              mapped;

  assign mapped = (32'(idx) < NREG);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)
      chain <= '0;
    else if (tlr)
      chain <= '0;
    else if (en) begin
      if (capture_dr)
        chain <= (dir == DIR_READ && mapped) ? rd_data : '0;
      else if (shift_dr)
        chain <= {tdi, chain[DATA_W-1:1]};
    end
  end

  assign rd_en   = en && !tlr && capture_dr && (dir == DIR_READ) && mapped;
  assign wr_en   = en && !tlr && update_dr && (dir == DIR_WRITE) && mapped;
  assign wr_data = chain;
  assign so      = chain[0];

  // R4: a read capture with a mapped index presents the register value
  p_capture_value_r4: assert property (@(posedge tck) disable iff (!rst_n)
    rd_en |=> (chain == $past(rd_data)));
endmodule

// File: rtl/jtag_regacc_client.sv
module jtag_regacc_client #(
  parameter int IDX_W    = 7,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 100
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              tap_tlr,
  input  logic              tap_capture_dr,
  input  logic              tap_shift_dr,
  input  logic              tap_update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic [IDX_W-1:0]  rf_addr,
  output logic              rf_rd_en,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_wr_en,
  output logic [DATA_W-1:0] rf_wr_data
);
  import jtp_pkg::*;

  pass_e            pass;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_dir;
  logic             sel_so;
  logic             data_so;
  logic             sel_en;
  logic             data_en;

  assign sel_en  = (pass == PASS_SEL);
  assign data_en = (pass == PASS_DATA);

  jtp_pass_ctl u_pass (
    .tck       (tck),
    .rst_n     (rst_n),
    .tlr       (tap_tlr),
    .update_dr (tap_update_dr),
    .pass      (pass)
  );

  jtp_sel_chain #(.IDX_W(IDX_W)) u_sel (
    .tck        (tck),
    .rst_n      (rst_n),
    .tlr        (tap_tlr),
    .en         (sel_en),
    .capture_dr (tap_capture_dr),
    .shift_dr   (tap_shift_dr),
    .update_dr  (tap_update_dr),
    .tdi        (tdi),
    .idx        (sel_idx),
    .dir        (sel_dir),
    .so         (sel_so)
  );

  jtp_data_chain #(
    .IDX_W    (IDX_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_data (
    .tck        (tck),
    .rst_n      (rst_n),
    .tlr        (tap_tlr),
    .en         (data_en),
    .dir        (sel_dir),
    .idx        (sel_idx),
    .capture_dr (tap_capture_dr),
    .shift_dr   (tap_shift_dr),
    .update_dr  (tap_update_dr),
    .tdi        (tdi),
    .rd_data    (rf_rd_data),
    .rd_en      (rf_rd_en),
    .wr_en      (rf_wr_en),
    .wr_data    (rf_wr_data),
    .so         (data_so)
  );

  assign rf_addr = sel_idx;
  assign tdo     = sel_en ? sel_so : data_so;

  // Input rule: the TAP strobes come from one decoded state
  p_strobe_onehot_r8: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({tap_capture_dr, tap_shift_dr, tap_update_dr}));

  // R5: a write strobe belongs to update-DR of a write data scan
  p_wr_in_data_r5: assert property (@(posedge tck) disable iff (!rst_n)
    rf_wr_en |-> (pass == PASS_DATA && tap_update_dr && sel_dir == DIR_WRITE));

  // R8: never both strobes, never a strobe in a selection scan
  p_strobe_excl_r8: assert property (@(posedge tck) disable iff (!rst_n)
    !(rf_rd_en && rf_wr_en) && !(sel_en && (rf_rd_en || rf_wr_en)));

  // R6: unmapped indices never reach the register file
  p_unmapped_quiet_r6: assert property (@(posedge tck) disable iff (!rst_n)
    (rf_rd_en || rf_wr_en) |-> (32'(rf_addr) < 32'(NUM_REGS)));

  // R7: test-logic-reset returns to selection with index 0
  p_tlr_clear_r7: assert property (@(posedge tck) disable iff (!rst_n)
    tap_tlr |=> (pass == PASS_SEL && rf_addr == '0 && !sel_dir));
endmodule

// File: tb/jtag_regacc_client_test.sv
`timescale 1ns/1ps
module jtag_regacc_client_test;
  localparam int NUM_REGS = 100;

  logic        tck = 1'b0;
  logic        rst_n = 1'b0;
  logic        tap_tlr = 1'b0, tap_capture_dr = 1'b0, tap_shift_dr = 1'b0, tap_update_dr = 1'b0;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [6:0]  rf_addr;
  logic        rf_rd_en, rf_wr_en;
  logic [31:0] rf_rd_data, rf_wr_data;

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, bad_wr = 0;
  logic [31:0] mem [NUM_REGS];
  logic [31:0] exp_mem [NUM_REGS];
  logic [7:0]  cur_sel = 8'h00;

  always #2.5 tck = ~tck;

  jtag_regacc_client #(.NUM_REGS(NUM_REGS)) uut (
    .tck(tck), .rst_n(rst_n), .tap_tlr(tap_tlr),
    .tap_capture_dr(tap_capture_dr), .tap_shift_dr(tap_shift_dr),
    .tap_update_dr(tap_update_dr), .tdi(tdi), .tdo(tdo),
    .rf_addr(rf_addr), .rf_rd_en(rf_rd_en), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data)
  );

  assign rf_rd_data = (int'(rf_addr) < NUM_REGS) ? mem[rf_addr] : 32'hDEAD_BEEF;

  always @(posedge tck) begin
    if (rf_rd_en) rd_cnt++;
    if (rf_wr_en) begin
      wr_cnt++;
      if (int'(rf_addr) >= NUM_REGS) bad_wr++;
      else mem[rf_addr] = rf_wr_data;
    end
  end

  function automatic logic [31:0] seed_val(input int i);
    return (32'h9E37_79B9 * 32'(i + 1)) ^ 32'(i) ^ 32'h0000_00A5;
  endfunction

  function automatic logic [31:0] exp_read(input logic [6:0] idx);
    return (int'(idx) < NUM_REGS) ? exp_mem[idx] : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic scan(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    @(negedge tck); tap_capture_dr = 1'b1;
    @(negedge tck); tap_capture_dr = 1'b0; tap_shift_dr = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge tck);
      tdi = din[i];
      #0.5;
      dout[i] = tdo;
    end
    @(negedge tck); tap_shift_dr = 1'b0; tap_update_dr = 1'b1;
    @(negedge tck); tap_update_dr = 1'b0;
  endtask

  // One full access: selection scan, then data scan
  task automatic access(input logic [6:0] idx, input logic dir, input logic [31:0] wdata);
    logic [31:0] prev, rdata;
    int rd0, wr0;
    bit mapped;
    mapped = int'(idx) < NUM_REGS;
    scan(8, {24'h0, dir, idx}, prev);
    chk("R2 selection readback", prev & 32'hFF, {24'h0, cur_sel});
    cur_sel = {dir, idx};
    chk("R1 committed index", {25'h0, rf_addr}, {25'h0, idx});
    rd0 = rd_cnt; wr0 = wr_cnt;
    scan(32, wdata, rdata);
    if (dir == 1'b0) begin
      chk(mapped ? "R4 read data" : "R6 unmapped reads zero", rdata, exp_read(idx));
      chk("R4 read strobe count", 32'(rd_cnt - rd0), mapped ? 32'd1 : 32'd0);
      chk("R8 no write on read", 32'(wr_cnt - wr0), 32'd0);
    end else begin
      chk(mapped ? "R5 write strobe count" : "R6 unmapped write ignored",
          32'(wr_cnt - wr0), mapped ? 32'd1 : 32'd0);
      chk("R8 no read on write", 32'(rd_cnt - rd0), 32'd0);
      if (mapped) begin
        exp_mem[idx] = wdata;
        chk("R5 written value", mem[idx], wdata);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [31:0] junk;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NUM_REGS; i++) begin
      mem[i] = seed_val(i);
      exp_mem[i] = seed_val(i);
    end
    repeat (3) @(negedge tck);
    rst_n = 1'b1;
    @(negedge tck); #0.5;
    chk("R7 reset tdo", {31'h0, tdo}, 32'h0);
    chk("R7 reset index", {25'h0, rf_addr}, 32'h0);
    chk("R8 reset strobes", {30'h0, rf_rd_en, rf_wr_en}, 32'h0);

    // Directed corners
    access(7'd0, 1'b0, 32'h0);
    access(7'd0, 1'b1, 32'hFFFF_FFFF);
    access(7'd0, 1'b0, 32'h0);
    access(7'(NUM_REGS - 1), 1'b1, 32'hA5A5_5A5A);
    access(7'(NUM_REGS - 1), 1'b0, 32'h1234_5678);
    access(7'(NUM_REGS), 1'b0, 32'h0);
    access(7'd127, 1'b1, 32'hCAFE_F00D);
    access(7'd127, 1'b0, 32'h0);
    access(7'd3, 1'b1, 32'h8000_0001);
    access(7'd3, 1'b0, 32'h0);

    // R7: reset mid-sequence, after a selection scan only
    access(7'd5, 1'b0, 32'h0);
    scan(8, {24'h0, 1'b0, 7'd9}, junk);
    chk("R2 readback before reset", junk & 32'hFF, {24'h0, cur_sel});
    chk("R3 now in data scan index", {25'h0, rf_addr}, 32'd9);
    @(negedge tck); tap_tlr = 1'b1;
    @(negedge tck); tap_tlr = 1'b0;
    chk("R7 tlr clears index", {25'h0, rf_addr}, 32'h0);
    cur_sel = 8'h00;
    access(7'd9, 1'b0, 32'h0);

    // Random accesses
    for (int k = 0; k < 150; k++) begin
      logic [6:0] ri;
      logic rd;
      ri = 7'($urandom_range(0, 127));
      rd = 1'($urandom);
      access(ri, rd, $urandom);
    end

    chk("R6 no unmapped write strobes", 32'(bad_wr), 32'h0);
    summary();
  end
endmodule